// File: doc/BRIEF.md
# Filtered Sensor-Input Edge Detector

This block conditions three asynchronous position-sensor lines and turns their transitions into single-cycle pulses for the logic that follows. Every line is first brought into the clock domain by a two-flop synchronizer. After that, each line either goes straight to edge detection or first passes through its own glitch filter. The choice is made per line by an enable bit.

The filter accepts a new level only after it has been seen for 2^n consecutive machine cycles. A machine cycle is a clock cycle in which the cycle enable is high. The exponent n is chosen per line and ranges from 2 to 5. While the clock-stopped indication is high, a filtered line keeps the level it last accepted.

A shared two-bit polarity field sets which transitions produce pulses. It can select none, rising only, falling only, or both. When a line's filter enable or length select changes, that line's counter is cleared and its accepted level is realigned to the synchronized input. No pulse is produced by such a change.

Top module: `snsedge_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `edge_pulse` bit is 0.
- R2: When `pol_sel` is 2'b00, no pulse appears on any pin, whatever the inputs do.
- R3: When `pol_sel` is 2'b01, a pin pulses only when its conditioned level goes from 0 to 1.
- R4: When `pol_sel` is 2'b10, a pin pulses only when its conditioned level goes from 1 to 0.
- R5: When `pol_sel` is 2'b11, a pin pulses on both kinds of transition, and each transition gives a pulse exactly one cycle wide.
- R6: On a bypassed pin (`filt_en[i]`=0), a change of `pin_raw[i]` applied between clock edges shows as a pulse after the 4th rising clock edge that follows.
- R7: On a filtered pin (`filt_en[i]`=1), the length code `len_sel[2i+1:2i]` selects n. The codes 00, 01, 10 and 11 give n = 2, 3, 4 and 5. With `cyc_en` held high, a held input change shows as a pulse after the (3+2^n)th rising clock edge.
- R8: On a filtered pin, an input pulse lasting 2^n-1 cycles produces no edge. One lasting 2^n cycles produces both of its edges.
- R9: A filter counter advances only on cycles with `cyc_en` high. With `cyc_en` low, a filtered pin produces no edge, while bypassed pins keep working.
- R10: While `clk_stopped` is high, a filtered pin accepts no level change and its counter is cleared. Bypassed pins are not affected.
- R11: Each pin uses only its own bits: `pin_raw[i]`, `filt_en[i]`, `len_sel[2i+1:2i]` and `edge_pulse[i]`. Pins with different lengths filter independently.
- R12: A change of a pin's `filt_en` bit or length code clears its counter and loads the synchronized input as its level, without producing a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle enable for the filter counters |
| clk_stopped | input | 1 | High while the internal clock is considered stopped |
| pin_raw | input | 3 | Asynchronous sensor inputs, bit i is pin i |
| pol_sel | input | 2 | Edge polarity: 00 off, 01 rising, 10 falling, 11 both |
| filt_en | input | 3 | Per-pin filter enable, 1 = filtered |
| len_sel | input | 6 | Per-pin length code, bits [2i+1:2i] for pin i |
| edge_pulse | output | 3 | Registered one-cycle edge pulses, bit i is pin i |

## Verification
The polarity properties compare each pulse with the registered level the detector saw on the cycle before. This rests on the control fields changing only between clock edges, since they are treated as quasi-static register values. The hold property for stop mode assumes that the filter enable and length code stay steady while the clock is stopped. The directed stimulus changes every control field and input at the falling clock edge. It also returns all pins to a settled idle state, with polarity off, before each scenario, so a configuration change never overlaps a measurement.

// File: rtl/snsedge_pkg.sv
package snsedge_pkg;

  typedef enum logic [1:0] {
    POL_OFF  = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_BOTH = 2'b11
  } pol_t;

  // smallest filter exponent, reached with length code 0
  localparam int FILT_N_MIN = 2;

endpackage

// File: rtl/snsedge_sync.sv
module snsedge_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/snsedge_filter.sv
module snsedge_filter #(
  parameter int LEN_W = 2,
  parameter int N_MIN = snsedge_pkg::FILT_N_MIN,
  localparam int N_MAX = N_MIN + (1 << LEN_W) - 1,
  localparam int CNT_W = N_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             din,
  input  logic             use_filt,
  input  logic [LEN_W-1:0] len_code,
  output logic             level,
  output logic             resync
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [LEN_W:0]   cfg_now;
  logic [LEN_W:0]   cfg_q;
  logic             cfg_chg;

  // terminal count is 2^n - 1, where n = N_MIN + len_code
  always_comb begin
    limit = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < N_MIN + int'(len_code)) limit[b] = 1'b1;
    end
  end

  assign cfg_now = {use_filt, len_code};
  assign cfg_chg = (cfg_now != cfg_q);

  // configuration shadow, compared every cycle
  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      level  <= 1'b0;
      resync <= 1'b0;
    end else begin
      resync <= 1'b0;
      if (cfg_chg) begin
        cnt_q  <= '0;
        level  <= din;
        resync <= 1'b1;
      end else if (!use_filt) begin
        cnt_q <= '0;
        level <= din;
      end else if (halt) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (din == level) begin
          cnt_q <= '0;
        end else if (cnt_q == limit) begin
          cnt_q <= '0;
          level <= din;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/snsedge_detect.sv
module snsedge_detect #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pol,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] pulse
);
  import snsedge_pkg::*;

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;

  always_comb begin
    case (pol_t'(pol))
      POL_RISE: hit = level & ~prev_q;
      POL_FALL: hit = ~level & prev_q;
      POL_BOTH: hit = level ^ prev_q;
      default:  hit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pulse  <= '0;
    end else begin
      prev_q <= level;
      pulse  <= hit & ~mask;
    end
  end

endmodule

// File: rtl/snsedge_top.sv
module snsedge_top #(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cyc_en,
  input  logic                      clk_stopped,
  input  logic [NUM_PINS-1:0]       pin_raw,
  input  logic [1:0]                pol_sel,
  input  logic [NUM_PINS-1:0]       filt_en,
  input  logic [NUM_PINS*LEN_W-1:0] len_sel,
  output logic [NUM_PINS-1:0]       edge_pulse
);

  logic [NUM_PINS-1:0] sync_w;
  logic [NUM_PINS-1:0] lvl_w;
  logic [NUM_PINS-1:0] resync_w;

  snsedge_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_raw),
    .dout(sync_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    snsedge_filter #(
      .LEN_W(LEN_W)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .tick    (cyc_en),
      .halt    (clk_stopped),
      .din     (sync_w[i]),
      .use_filt(filt_en[i]),
      .len_code(len_sel[i*LEN_W +: LEN_W]),
      .level   (lvl_w[i]),
      .resync  (resync_w[i])
    );
  end

  snsedge_detect #(
    .WIDTH(NUM_PINS)
  ) u_det (
    .clk  (clk),
    .rst  (rst),
    .pol  (pol_sel),
    .level(lvl_w),
    .mask (resync_w),
    .pulse(edge_pulse)
  );

endmodule

// File: rtl/snsedge_chk.sv
module snsedge_chk #(
  parameter int NUM_PINS = 3,
  parameter int LEN_W    = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      clk_stopped,
  input logic [1:0]                pol_sel,
  input logic [NUM_PINS-1:0]       filt_en,
  input logic [NUM_PINS*LEN_W-1:0] len_sel,
  input logic [NUM_PINS-1:0]       lvl,
  input logic [NUM_PINS-1:0]       edge_pulse
);

  // R1: reset clears the pulse outputs
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (edge_pulse == '0));

  // R2: polarity off yields no pulse
  assert_pol_off_R2: assert property (@(posedge clk) disable iff (rst)
    (pol_sel == 2'b00) |=> (edge_pulse == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R3: rising-only pulses follow a level that had gone high
    assert_rise_only_R3: assert property (@(posedge clk) disable iff (rst)
      (edge_pulse[i] && $past(pol_sel) == 2'b01) |-> $past(lvl[i]));

    // R4: falling-only pulses follow a level that had gone low
    assert_fall_only_R4: assert property (@(posedge clk) disable iff (rst)
      (edge_pulse[i] && $past(pol_sel) == 2'b10) |-> !$past(lvl[i]));

    // R10: filtered level is frozen while the clock is stopped
    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (clk_stopped && filt_en[i] && $stable(filt_en) && $stable(len_sel))
        |=> $stable(lvl[i]));
  end

endmodule

bind snsedge_top snsedge_chk #(
  .NUM_PINS(NUM_PINS),
  .LEN_W   (LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_stopped(clk_stopped),
  .pol_sel    (pol_sel),
  .filt_en    (filt_en),
  .len_sel    (len_sel),
  .lvl        (lvl_w),
  .edge_pulse (edge_pulse)
);

// File: tb/snsedge_top_test.sv
`timescale 1ns/1ps
module snsedge_top_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       cyc_en;
  logic       clk_stopped;
  logic [2:0] pin_raw;
  logic [1:0] pol_sel;
  logic [2:0] filt_en;
  logic [5:0] len_sel;
  logic [2:0] edge_pulse;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int hits  [3];
  int first [3];

  always #2.5 clk = ~clk;

  snsedge_top uut (
    .clk        (clk),
    .rst        (rst),
    .cyc_en     (cyc_en),
    .clk_stopped(clk_stopped),
    .pin_raw    (pin_raw),
    .pol_sel    (pol_sel),
    .filt_en    (filt_en),
    .len_sel    (len_sel),
    .edge_pulse (edge_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample n falling edges, recording pulse counts and first-hit index
  task automatic observe(input int n);
    for (int p = 0; p < 3; p++) begin hits[p] = 0; first[p] = -1; end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (edge_pulse[p]) begin
          hits[p]++;
          if (first[p] < 0) first[p] = k;
        end
      end
    end
  endtask

  task automatic settle();
    pol_sel = 2'b00; pin_raw = 3'b000; clk_stopped = 1'b0; cyc_en = 1'b1;
    repeat (50) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc_en = 1'b1; clk_stopped = 1'b0; pin_raw = 3'b111;
    pol_sel = 2'b11; filt_en = 3'b000; len_sel = 6'd0;
    repeat (4) @(negedge clk);
    check("R1 pulses during reset", int'(edge_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pulses first cycle after reset", int'(edge_pulse), 0);
    settle();
  endtask

  task automatic t_polarity();
    filt_en = 3'b000; len_sel = 6'd0;
    for (int pv = 0; pv < 4; pv++) begin
      settle();
      pol_sel = 2'(pv);
      pin_raw = 3'b001;
      observe(8);
      check($sformatf("R2/R3/R5 rise count pol=%0d", pv), hits[0],
            (pv == 1 || pv == 3) ? 1 : 0);
      check("R11 other pins quiet on rise", hits[1] + hits[2], 0);
      if (pv == 1) check("R6 bypass rise latency", first[0], 4);
      pin_raw = 3'b000;
      observe(8);
      check($sformatf("R2/R4/R5 fall count pol=%0d", pv), hits[0],
            (pv == 2 || pv == 3) ? 1 : 0);
      if (pv == 2) check("R6 bypass fall latency", first[0], 4);
    end
  endtask

  task automatic t_filter_len();
    filt_en = 3'b010;
    for (int c = 0; c < 4; c++) begin
      len_sel = 6'(c << 2);
      settle();
      pol_sel = 2'b01;
      pin_raw = 3'b010;
      observe(45);
      check($sformatf("R7 filtered pulse count code=%0d", c), hits[1], 1);
      check($sformatf("R7 filtered latency code=%0d", c), first[1], 3 + (1 << (c + 2)));
    end
  endtask

  task automatic t_reject();
    int tot;
    filt_en = 3'b010; len_sel = 6'b00_01_00;
    settle();
    pol_sel = 2'b11;
    pin_raw = 3'b010; observe(7); tot = hits[1];
    pin_raw = 3'b000; observe(45); tot += hits[1];
    check("R8 width 2^n-1 rejected", tot, 0);
    settle();
    pol_sel = 2'b11;
    pin_raw = 3'b010; observe(8); tot = hits[1];
    pin_raw = 3'b000; observe(45); tot += hits[1];
    check("R8 width 2^n accepted (two edges)", tot, 2);
  endtask

  task automatic t_indep();
    filt_en = 3'b111; len_sel = 6'b11_10_00;
    settle();
    pol_sel = 2'b01;
    pin_raw = 3'b111;
    observe(45);
    check("R11 pin0 n=2 latency", first[0], 7);
    check("R11 pin1 n=4 latency", first[1], 19);
    check("R11 pin2 n=5 latency", first[2], 35);
  endtask

  task automatic t_cycen();
    filt_en = 3'b001; len_sel = 6'd0;
    settle();
    pol_sel = 2'b11; cyc_en = 1'b0;
    pin_raw = 3'b011;
    observe(30);
    check("R9 filtered pin frozen with cyc_en low", hits[0], 0);
    check("R9 bypass pin active with cyc_en low", hits[1], 1);
    cyc_en = 1'b1;
    observe(20);
    check("R9 filtered pin accepts after cyc_en high", hits[0], 1);
  endtask

  task automatic t_stop();
    filt_en = 3'b001; len_sel = 6'd0;
    settle();
    pol_sel = 2'b11; clk_stopped = 1'b1;
    pin_raw = 3'b011;
    observe(30);
    check("R10 filtered pin held while stopped", hits[0], 0);
    check("R10 bypass pin active while stopped", hits[1], 1);
    clk_stopped = 1'b0;
    observe(20);
    check("R10 filtered pin accepts after restart", hits[0], 1);
  endtask

  task automatic t_cfg();
    filt_en = 3'b001; len_sel = 6'b00_00_11;
    settle();
    pol_sel = 2'b11;
    pin_raw = 3'b001;
    observe(10);
    check("R12 no pulse before filter expiry", hits[0], 0);
    filt_en = 3'b000;
    observe(10);
    check("R12 no pulse on filter disable", hits[0], 0);
    pin_raw = 3'b000;
    observe(8);
    check("R12 later fall still detected", hits[0], 1);
    filt_en = 3'b001; len_sel = 6'b00_00_11;
    settle();
    pol_sel = 2'b11;
    pin_raw = 3'b001;
    observe(20);
    len_sel = 6'b00_00_00;
    observe(40);
    check("R12 no pulse on length change mid-count", hits[0], 0);
  endtask

  initial begin
    t_reset();
    t_polarity();
    t_filter_len();
    t_reject();
    t_indep();
    t_cycen();
    t_stop();
    t_cfg();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule